// File: doc/BRIEF.md
# Prescaled Countdown Timer for a Local Interrupt Controller

This block is the per-processor countdown timer of a local interrupt controller. Software loads a starting count, chooses a tick divider and writes a control word with a mask bit, a one-shot or periodic select and an interrupt vector. The timer counts down once per prescaled tick. When the count expires, and the timer is not masked, it raises a one-cycle interrupt request that carries the vector.

Registers are written through four separate write strobes that share a 32-bit data bus. The current state of every register, including the live count, is always visible on dedicated readback outputs. Address decoding and delivery of the interrupt after expiry are left to the surrounding logic.

Top module: `irq_countdown_timer`

## Requirements
- R1: A divide write keeps only data bits 3, 1 and 0. Bit 2 reads back as zero. The code {bit3, bit1, bit0} selects a tick period of 2^((code+1) mod 8) clocks, so code 3'b111 divides by 1, 3'b000 by 2, 3'b011 by 16 and 3'b110 by 128.
- R2: After reset the control word reads 0x0001_0000 (masked, one-shot, vector 0). The divide register, the initial count and the current count read 0, and no interrupt is raised.
- R3: Writing the initial count loads the current count on the same edge and clears the prescaler. The first decrement comes a full tick period after the load, and the current count never exceeds the initial count.
- R4: In one-shot mode (control bit 17 = 0) the count falls by one per tick and stays at zero. One interrupt comes out exactly (initial+1) × period clocks after the load edge. A zero initial count gives no interrupt.
- R5: In periodic mode (control bit 17 = 1) the count steps initial, initial−1, …, 0 and then reloads to initial. An interrupt comes out every (initial+1) × period clocks.
- R6: In periodic mode an initial count of zero never produces an interrupt.
- R7: While control bit 16 (mask) is set, no interrupt comes out, but counting continues. A one-shot expiry that happens while masked is used up and does not fire later.
- R8: Each interrupt is a single-cycle pulse on irq_o. irq_vec_o holds control bits 7:0 as they stood in the cycle before the pulse.
- R9: The control readback shows bits 17, 16 and 7:0 as written, with all other bits zero. Writes through the current-count strobe have no effect.
- R10: A control write takes effect from the next edge, so unmasking between two periodic expiries lets the very next expiry fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the source of the prescaled ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| init_wr | input | 1 | Write strobe for the initial count |
| cur_wr | input | 1 | Write strobe for the current count (ignored) |
| div_wr | input | 1 | Write strobe for the divide configuration |
| ctl_wr | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Write data shared by all strobes |
| init_q | output | 32 | Initial count readback |
| cur_q | output | 32 | Live current count |
| div_q | output | 4 | Divide configuration readback |
| ctl_q | output | 32 | Control word readback |
| irq_o | output | 1 | One-cycle expiry interrupt request |
| irq_vec_o | output | 8 | Vector carried with irq_o |

## Verification
Most internal faults show up at the ports within a tick period. A wrong prescaler phase or divide decode moves the first change of cur_q and the cycle of every interrupt, and a scoreboard that predicts each interrupt's exact cycle catches this. A wrong reload value or a lost one-shot armed flag shows as an off-by-one period, a repeated one-shot pulse or a missing periodic pulse, at the next expiry. Mask and vector faults appear on the first pulse that should or should not come out.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int BUS_W        = 32;
   localparam int CTL_MASK_BIT = 16;
   localparam int CTL_PER_BIT  = 17;
   localparam int DIV_W        = 4;
   localparam int SHIFT_W      = 3;
   localparam int MAX_SHIFT    = (1 << SHIFT_W) - 1;

   typedef enum logic {
      MODE_ONESHOT  = 1'b0,
      MODE_PERIODIC = 1'b1
   } cdt_mode_e;

   typedef struct packed {
      logic      masked;
      cdt_mode_e mode;
      logic [7:0] vec;
   } cdt_ctl_t;

   // tick period exponent from the stored divide field {b3,b2(zero),b1,b0}
   function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_W-1:0] d);
      logic [SHIFT_W-1:0] code;
      code = {d[3], d[1], d[0]};
      return code + SHIFT_W'(1);
   endfunction
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
   parameter int SHIFT_W = 3,
   parameter int PRE_W   = (1 << SHIFT_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] lim;

   generate
      if (PRE_W < (1 << SHIFT_W) - 1) begin : g_bad_width
         $error("cdt_prescale: PRE_W too narrow for the largest shift");
      end
   endgenerate

   always_comb begin
      lim  = PRE_W'((32'd1 << shift) - 32'd1);
      tick = (pcnt >= lim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     pcnt <= '0;
      else if (clear) pcnt <= '0;
      else if (tick)  pcnt <= '0;
      else            pcnt <= pcnt + PRE_W'(1);
   end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] cur,
   output logic             expire
);
   logic armed;
   logic at_zero;

   always_comb begin
      at_zero = (cur == '0);
      expire  = tick && !load && at_zero &&
                (periodic ? (reload_val != '0) : armed);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur   <= '0;
         armed <= 1'b0;
      end else if (load) begin
         cur   <= load_val;
         armed <= (load_val != '0);
      end else if (tick) begin
         if (!at_zero)     cur <= cur - CNT_W'(1);
         else if (periodic) cur <= reload_val;
         if (expire && !periodic) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
   import cdt_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_wr,
   input  logic             cur_wr,
   input  logic             div_wr,
   input  logic             ctl_wr,
   input  logic [31:0]      wdata,
   output logic [31:0]      init_q,
   output logic [31:0]      cur_q,
   output logic [3:0]       div_q,
   output logic [31:0]      ctl_q,
   output logic             irq_o,
   output logic [7:0]       irq_vec_o
);
   localparam int PRE_W = (1 << SHIFT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("irq_countdown_timer: CNT_W must be 2..BUS_W");
      end
      if (VEC_W != 8) begin : g_bad_vec
         $error("irq_countdown_timer: VEC_W must be 8");
      end
   endgenerate

   logic [CNT_W-1:0]   init_r;
   logic [CNT_W-1:0]   cur;
   logic [DIV_W-1:0]   div_r;
   cdt_ctl_t           ctl_r;
   logic [SHIFT_W-1:0] shift;
   logic               tick;
   logic               expire;
   logic               unused_bits;

   assign unused_bits = ^{cur_wr, wdata[31:18], wdata[15:8]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_r       <= '0;
         div_r        <= '0;
         ctl_r.masked <= 1'b1;
         ctl_r.mode   <= MODE_ONESHOT;
         ctl_r.vec    <= '0;
      end else begin
         if (init_wr) init_r <= wdata[CNT_W-1:0];
         if (div_wr)  div_r  <= {wdata[3], 1'b0, wdata[1], wdata[0]};
         if (ctl_wr) begin
            ctl_r.masked <= wdata[CTL_MASK_BIT];
            ctl_r.mode   <= cdt_mode_e'(wdata[CTL_PER_BIT]);
            ctl_r.vec    <= wdata[VEC_W-1:0];
         end
      end
   end

   assign shift = div_shift(div_r);

   cdt_prescale #(.SHIFT_W(SHIFT_W), .PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (init_wr),
      .shift (shift),
      .tick  (tick)
   );

   cdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (init_wr),
      .load_val   (wdata[CNT_W-1:0]),
      .reload_val (init_r),
      .tick       (tick),
      .periodic   (ctl_r.mode == MODE_PERIODIC),
      .cur        (cur),
      .expire     (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o     <= 1'b0;
         irq_vec_o <= '0;
      end else begin
         irq_o     <= expire && !ctl_r.masked;
         irq_vec_o <= ctl_r.vec;
      end
   end

   always_comb begin
      init_q                = '0;
      init_q[CNT_W-1:0]     = init_r;
      cur_q                 = '0;
      cur_q[CNT_W-1:0]      = cur;
      div_q                 = div_r;
      ctl_q                 = '0;
      ctl_q[CTL_PER_BIT]    = (ctl_r.mode == MODE_PERIODIC);
      ctl_q[CTL_MASK_BIT]   = ctl_r.masked;
      ctl_q[VEC_W-1:0]      = ctl_r.vec;
   end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
   parameter int VEC_W = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        init_wr,
   input logic [31:0] init_q,
   input logic [31:0] cur_q,
   input logic [3:0]  div_q,
   input logic [31:0] ctl_q,
   input logic        irq_o,
   input logic [7:0]  irq_vec_o
);
   // R8
   irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R8
   irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_vec_o == $past(ctl_q[VEC_W-1:0])));

   // R7
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !$past(ctl_q[16]));

   // R3
   cur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q <= init_q);

   // R4
   oneshot_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(init_wr) && !$past(ctl_q[17])) |-> (cur_q <= $past(cur_q)));

   // R1
   div_bit2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_q[2] == 1'b0);

   // R5
   irq_count_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cur_q == ($past(ctl_q[17]) ? init_q : 32'd0)));
endmodule

bind irq_countdown_timer cdt_timer_chk #(.VEC_W(VEC_W)) u_cdt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .init_wr   (init_wr),
   .init_q    (init_q),
   .cur_q     (cur_q),
   .div_q     (div_q),
   .ctl_q     (ctl_q),
   .irq_o     (irq_o),
   .irq_vec_o (irq_vec_o)
);

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
module test_irq_countdown_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_wr = 1'b0, cur_wr = 1'b0, div_wr = 1'b0, ctl_wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] init_q, cur_q, ctl_q;
   logic [3:0]  div_q;
   logic        irq_o;
   logic [7:0]  irq_vec_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct { int at; logic [7:0] vec; } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   irq_countdown_timer i_irq_countdown_timer (
      .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .cur_wr(cur_wr),
      .div_wr(div_wr), .ctl_wr(ctl_wr), .wdata(wdata), .init_q(init_q),
      .cur_q(cur_q), .div_q(div_q), .ctl_q(ctl_q), .irq_o(irq_o),
      .irq_vec_o(irq_vec_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // which: 0 init, 1 cur, 2 div, 3 ctl. Returns the capture cycle.
   task automatic wr(input int which, input logic [31:0] d, output int w);
      wdata = d;
      init_wr = (which == 0);
      cur_wr  = (which == 1);
      div_wr  = (which == 2);
      ctl_wr  = (which == 3);
      w = cyc + 1;
      @(negedge clk);
      init_wr = 1'b0; cur_wr = 1'b0; div_wr = 1'b0; ctl_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_irq(input int at, input logic [7:0] v);
      exp_t e;
      e.at = at; e.vec = v;
      sb.push_back(e);
   endtask

   // scoreboard monitor (R8, plus every timing requirement)
   always @(negedge clk) begin
      if (rst_n) begin
         if (sb.size() > 0 && sb[0].at < cyc) begin
            checks++; failures++;
            $display("FAIL R8: actual=no irq expected=irq vec 0x%02h at cycle %0d", sb[0].vec, sb[0].at);
            void'(sb.pop_front());
         end
         if (irq_o) begin
            checks++;
            if (sb.size() > 0 && sb[0].at == cyc && irq_vec_o == sb[0].vec) begin
               void'(sb.pop_front());
            end else begin
               failures++;
               $display("FAIL R8: actual=irq vec 0x%02h at cycle %0d expected=%s", irq_vec_o, cyc,
                        (sb.size() > 0) ? $sformatf("cycle %0d vec 0x%02h", sb[0].at, sb[0].vec) : "none");
            end
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : drive
      int w, w2, sc;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R2 reset state
      chk("R2 ctl", ctl_q, 32'h0001_0000);
      chk("R2 div", {28'd0, div_q}, 32'd0);
      chk("R2 init", init_q, 32'd0);
      chk("R2 cur", cur_q, 32'd0);
      chk("R2 irq", {31'd0, irq_o}, 32'd0);

      // R1 default code 000 -> divide by 2; R4 one-shot
      wr(3, 32'h0000_0033, w);
      wr(0, 32'd3, w);
      expect_irq(w + 8, 8'h33);
      chk("R3 loaded", cur_q, 32'd3);
      idle(1);
      chk("R3 no early tick", cur_q, 32'd3);
      idle(1);
      chk("R1 div2 first tick", cur_q, 32'd2);
      idle(20);
      chk("R4 stays zero", cur_q, 32'd0);

      // R1 divide by 1, field masking
      wr(2, 32'hFFFF_FFFF, w);
      chk("R1 div readback", {28'd0, div_q}, 32'hB);
      wr(0, 32'd5, w);
      expect_irq(w + 6, 8'h33);
      idle(2);
      chk("R4 decrement", cur_q, 32'd3);
      wr(1, 32'd0, w2);
      chk("R9 cur write ignored", cur_q, 32'd2);
      idle(15);

      // R1 divide by 16 (code 011)
      wr(2, 32'h3, w);
      wr(0, 32'd2, w);
      expect_irq(w + 48, 8'h33);
      idle(60);
      // R1 divide by 128 (code 110)
      wr(2, 32'hA, w);
      wr(0, 32'd1, w);
      expect_irq(w + 256, 8'h33);
      idle(270);

      // R5 periodic, R7 mask, R10 unmask timing
      wr(2, 32'hB, w);
      wr(3, 32'h0002_0055, w);
      chk("R9 ctl readback", ctl_q, 32'h0002_0055);
      wr(0, 32'd3, w);
      expect_irq(w + 4, 8'h55);
      expect_irq(w + 8, 8'h55);
      expect_irq(w + 12, 8'h55);
      idle(13);
      chk("R5 reload sequence", cur_q, 32'd2);
      wr(3, 32'h0003_0055, w2);
      idle(20);
      chk("R7 counts while masked", cur_q, 32'd1);
      wr(3, 32'h0002_0055, w2);
      expect_irq(w + 36, 8'h55); // R10
      expect_irq(w + 40, 8'h55);
      idle(5);
      wr(3, 32'h0001_0000, w2);
      chk("R5 all periodic pulses seen", sb.size(), 0);

      // R6 periodic with zero initial count
      wr(3, 32'h0002_0066, w);
      wr(0, 32'd0, w);
      idle(40);
      chk("R6 cur zero", cur_q, 32'd0);
      // R4 one-shot with zero initial count
      wr(3, 32'h0000_0066, w);
      wr(0, 32'd0, w);
      idle(20);
      chk("R6 R4 no pulses", sb.size(), 0);

      // R3 restart clears prescaler (divide by 4, code 001)
      wr(3, 32'h0000_0077, w);
      wr(2, 32'h1, w);
      wr(0, 32'd10, w);
      idle(6);
      wr(0, 32'd1, w2);
      expect_irq(w2 + 8, 8'h77);
      idle(3);
      chk("R3 restart phase", cur_q, 32'd1);
      idle(1);
      chk("R3 restart tick", cur_q, 32'd0);
      idle(60);

      // R7 one-shot expiry while masked is used up
      wr(2, 32'hB, w);
      wr(3, 32'h0001_0088, w);
      wr(0, 32'd2, w);
      idle(10);
      wr(3, 32'h0000_0088, w);
      idle(20);
      chk("R7 masked expiry consumed", cur_q, 32'd0);

      // R9 reserved control bits read zero
      wr(3, 32'hFFFF_FFFF, w);
      chk("R9 ctl reserved", ctl_q, 32'h0003_00FF);
      idle(5);
      chk("R8 scoreboard drained", sb.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule